// File: doc/BRIEF.md
# Static Branch Direction Predictor

This block guesses whether a conditional branch will be taken using only the branch itself: its address, its target address and an optional two-bit software hint. It keeps no history. It is meant as the fallback path next to a dynamic predictor. When the dynamic predictor says it knows this branch, its guess is passed straight through. When it does not, the static rule decides.

Two rule sets can be picked through a configuration input. The first always predicts not taken, so fetch always continues sequentially. The second predicts taken for branches that jump backward (loops) and not taken for branches that jump forward. In that mode an explicit hint on the instruction replaces the address comparison. The chosen direction and the next fetch address are registered, and they appear one clock after the request.

Top module: `static_bp`

## Requirements
- R1: With `mode_sel` = 0 (sequential mode) and `dyn_known` low, the prediction is not taken, whatever the addresses and the hint field.
- R2: With `mode_sel` = 1 (direction mode), no hint and `dyn_known` low, a branch whose target is numerically lower than its own address is predicted taken.
- R3: With `mode_sel` = 1, no hint and `dyn_known` low, a branch whose target is numerically higher than its own address is predicted not taken.
- R4: With `mode_sel` = 1, no hint and `dyn_known` low, a target equal to the branch address counts as backward and is predicted taken.
- R5: With `mode_sel` = 1 and `dyn_known` low, hint code 2'b10 forces taken and hint code 2'b01 forces not taken, overriding the address comparison.
- R6: Hint codes 2'b00 and 2'b11 carry no hint, and the address rule applies.
- R7: When `dyn_known` is high, `pred_taken` equals `dyn_taken`, in either mode and with any hint.
- R8: `next_pc` is `tgt_addr` when the prediction is taken. Otherwise it is `br_addr` + 4, wrapping modulo 2^ADDR_W.
- R9: `pred_valid` equals `req_valid` delayed by one clock. `pred_taken` and `next_pc` belong to the request accepted on the previous edge.
- R10: A clock edge with `req_valid` low leaves `pred_taken` and `next_pc` unchanged.
- R11: While `rst` is high, `pred_valid`, `pred_taken` and `next_pc` are all zero on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A branch is presented this cycle |
| mode_sel | input | 1 | 0 = always sequential, 1 = backward taken / forward not taken |
| br_addr | input | ADDR_W | Address of the branch instruction |
| tgt_addr | input | ADDR_W | Target address of the branch |
| hint | input | 2 | 00 none, 01 not taken, 10 taken, 11 none |
| dyn_known | input | 1 | Dynamic predictor holds information for this branch |
| dyn_taken | input | 1 | Dynamic predictor's direction guess |
| pred_valid | output | 1 | Registered prediction is valid |
| pred_taken | output | 1 | Registered direction guess |
| next_pc | output | ADDR_W | Registered next fetch address |

## Verification
The bench targets the equal-address case. A design that used a strict less-than comparison would predict that self-loop not taken and fetch past it. It sends the reserved hint code 11, which a decoder that tested only one bit would treat as taken or as not taken. It places a not-taken branch at the top of the address space, where a design with a truncated or widened adder would give a fall-through address other than zero. It also sends hints and backward targets in sequential mode and with the dynamic predictor holding information, and it leaves idle cycles between requests. A wrong priority order, a hint that leaks into sequential mode, or outputs that drift while no request is presented each show up as a direction or address mismatch against the cycle-level model.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic [1:0] {
    HINT_NONE = 2'b00,
    HINT_NT   = 2'b01,
    HINT_T    = 2'b10,
    HINT_RSV  = 2'b11
  } hint_e;

  typedef enum logic {
    MODE_SEQ  = 1'b0,
    MODE_BTFN = 1'b1
  } mode_e;
endpackage

// File: rtl/sbp_hint_decode.sv
module sbp_hint_decode
  import sbp_pkg::*;
(
  input  logic [1:0] hint_code,
  output logic       hint_present,
  output logic       hint_taken
);
  hint_e code;
  assign code = hint_e'(hint_code);

  always_comb begin
    hint_present = 1'b0;
    hint_taken   = 1'b0;
    case (code)
      HINT_NT: hint_present = 1'b1;
      HINT_T: begin
        hint_present = 1'b1;
        hint_taken   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sbp_dir_rule.sv
module sbp_dir_rule
  import sbp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  mode_e              mode,
  input  logic [ADDR_W-1:0]  br_addr,
  input  logic [ADDR_W-1:0]  tgt_addr,
  input  logic               hint_present,
  input  logic               hint_taken,
  output logic               static_taken
);
  logic backward;
  assign backward = (tgt_addr <= br_addr);

  always_comb begin
    if (mode == MODE_SEQ)  static_taken = 1'b0;
    else if (hint_present) static_taken = hint_taken;
    else                   static_taken = backward;
  end
endmodule

// File: rtl/sbp_next_pc.sv
module sbp_next_pc #(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              taken,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic [ADDR_W-1:0] fetch_addr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);
  logic [ADDR_W-1:0] seq_addr;
  assign seq_addr   = br_addr + STEP;
  assign fetch_addr = taken ? tgt_addr : seq_addr;
endmodule

// File: rtl/static_bp.sv
module static_bp
  import sbp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              mode_sel,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [1:0]        hint,
  input  logic              dyn_known,
  input  logic              dyn_taken,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] next_pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  logic              h_present, h_taken, s_taken, final_taken;
  logic [ADDR_W-1:0] fetch_d;

  sbp_hint_decode u_hint (
    .hint_code    (hint),
    .hint_present (h_present),
    .hint_taken   (h_taken)
  );

  sbp_dir_rule #(.ADDR_W(ADDR_W)) u_rule (
    .mode         (mode_e'(mode_sel)),
    .br_addr      (br_addr),
    .tgt_addr     (tgt_addr),
    .hint_present (h_present),
    .hint_taken   (h_taken),
    .static_taken (s_taken)
  );

  assign final_taken = dyn_known ? dyn_taken : s_taken;

  sbp_next_pc #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_npc (
    .taken      (final_taken),
    .br_addr    (br_addr),
    .tgt_addr   (tgt_addr),
    .fetch_addr (fetch_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
      next_pc    <= '0;
    end else begin
      pred_valid <= req_valid;
      if (req_valid) begin
        pred_taken <= final_taken;
        next_pc    <= fetch_d;
      end
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> pred_valid);

  // R7
  dyn_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && dyn_known) |=> (pred_taken == $past(dyn_taken)));

  // R1
  seq_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !dyn_known && !mode_sel) |=> !pred_taken);

  // R8
  fallthru_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !dyn_known && !mode_sel) |=> (next_pc == $past(br_addr) + STEP));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(pred_taken) && $stable(next_pc)));
endmodule

// File: tb/test_static_bp.sv
module test_static_bp;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid, mode_sel, dyn_known, dyn_taken;
  logic [W-1:0] br_addr, tgt_addr;
  logic [1:0]   hint;
  logic         pred_valid, pred_taken;
  logic [W-1:0] next_pc;

  int tests = 0;
  int fails = 0;

  logic         e_valid, e_taken;
  logic [W-1:0] e_pc;
  string        e_tag;

  always #2 clk = ~clk;

  static_bp i_static_bp (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mode_sel(mode_sel),
    .br_addr(br_addr), .tgt_addr(tgt_addr), .hint(hint),
    .dyn_known(dyn_known), .dyn_taken(dyn_taken),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .next_pc(next_pc)
  );

  task automatic check_outputs();
    tests++;
    if (pred_valid !== e_valid) begin
      fails++;
      $display("FAIL R9 pred_valid actual=%0b expected=%0b", pred_valid, e_valid);
    end
    tests++;
    if (pred_taken !== e_taken) begin
      fails++;
      $display("FAIL %s pred_taken actual=%0b expected=%0b", e_tag, pred_taken, e_taken);
    end
    tests++;
    if (next_pc !== e_pc) begin
      fails++;
      $display("FAIL R8/%s next_pc actual=%h expected=%h", e_tag, next_pc, e_pc);
    end
  endtask

  // Called at a falling edge: check what the last rising edge produced, then apply new stimulus
  task automatic step(input logic r, input logic v, input logic m, input logic [W-1:0] b,
                      input logic [W-1:0] t, input logic [1:0] h, input logic dk, input logic dt);
    bit t_now;
    check_outputs();
    rst = r; req_valid = v; mode_sel = m; br_addr = b; tgt_addr = t;
    hint = h; dyn_known = dk; dyn_taken = dt;
    if (r) begin
      e_valid = 0; e_taken = 0; e_pc = '0; e_tag = "R11";
    end else begin
      e_valid = v;
      if (v) begin
        if (dk) begin
          t_now = dt; e_tag = "R7";
        end else if (!m) begin
          t_now = 0; e_tag = "R1";
        end else if (h == 2'b10) begin
          t_now = 1; e_tag = "R5";
        end else if (h == 2'b01) begin
          t_now = 0; e_tag = "R5";
        end else begin
          if (t == b) e_tag = (h == 2'b11) ? "R6/R4" : "R4";
          else        e_tag = (h == 2'b11) ? "R6" : ((t < b) ? "R2" : "R3");
          t_now = (t <= b);
        end
        e_taken = t_now;
        e_pc    = t_now ? t : b + 32'd4;
      end else begin
        e_tag = "R10";
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1; req_valid = 0; mode_sel = 0; br_addr = '0; tgt_addr = '0;
    hint = 0; dyn_known = 0; dyn_taken = 0;
    e_valid = 0; e_taken = 0; e_pc = '0; e_tag = "R11";
    @(negedge clk); @(negedge clk);
    // R11: reset state, while dirty inputs are presented
    step(1, 1, 1, 32'h100, 32'h80, 2'b10, 1, 1);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    // R1: sequential mode ignores hints and backward targets
    step(0, 1, 0, 32'h1000, 32'h0800, 2'b00, 0, 0);
    step(0, 1, 0, 32'h1000, 32'h0800, 2'b10, 0, 0);
    // R2 / R3 / R4
    step(0, 1, 1, 32'h2000, 32'h1F00, 2'b00, 0, 0);
    step(0, 1, 1, 32'h2000, 32'h2100, 2'b00, 0, 0);
    step(0, 1, 1, 32'h3000, 32'h3000, 2'b00, 0, 0);
    // R5: hints override the address rule
    step(0, 1, 1, 32'h4000, 32'h5000, 2'b10, 0, 0);
    step(0, 1, 1, 32'h4000, 32'h3000, 2'b01, 0, 0);
    // R6: the reserved code acts as no hint
    step(0, 1, 1, 32'h4000, 32'h3000, 2'b11, 0, 0);
    step(0, 1, 1, 32'h4000, 32'h5000, 2'b11, 0, 0);
    // R7: the dynamic guess wins
    step(0, 1, 0, 32'h6000, 32'h7000, 2'b00, 1, 1);
    step(0, 1, 1, 32'h6000, 32'h5000, 2'b10, 1, 0);
    // R8: fall-through address wraps at the top of the address space
    step(0, 1, 1, 32'hFFFF_FFFC, 32'hFFFF_FFFF, 2'b00, 0, 0);
    // R10: idle cycles hold the last result
    step(0, 0, 1, 32'h10, 32'h8, 2'b10, 1, 1);
    step(0, 0, 0, 32'h20, 32'h8, 2'b01, 0, 0);
    // mixed patterns
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] b, t;
      b = $urandom;
      t = ($urandom_range(0, 7) == 0) ? b : $urandom;
      step(0, 1'($urandom_range(0, 3) != 0), 1'($urandom), b, t,
           2'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0);
    check_outputs();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule